// File: doc/BRIEF.md
# Double-Buffered Backlight PWM Generator

This block produces one pulse-width-modulated output for a display backlight. A prescaler slows the input clock by a programmable ratio, a period counter steps once per prescaler tick, and the output is high while that counter is below a programmed high width. The output is always high first in each period and low for the rest.

Software programs the block through a word-addressed register bus with a write enable, address, write data and combinational read data. Divider, period and high width are first written into staged copies. They go live only after a commit bit is written from 0 to 1. A pending commit takes effect at the next period boundary, so the output never shows a cut-short period. A mode field can turn the staging off, so that staged values follow into the live set at each boundary with no commit. An enable bit starts the counters. Clearing it holds them at zero and forces the output low.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset, every register reads as zero and `pwm_o` is low.
- R2: With live divider D and period field P (encoded as count minus one), one output period lasts (D+1)*(P+1) clock cycles.
- R3: With live high width H (a true count, 0 < H <= P), the output is high for the first (D+1)*H cycles of each period and low for the rest.
- R4: The divider is stored in bits [25:16] at address 2. The period is stored in bits [11:0] and the high width in bits [28:16] at address 3. These reads return the staged values, and every other bit reads as zero.
- R5: Staged writes leave the output unchanged until bit 0 at address 1 goes from 0 to 1. That bit reads back as written.
- R6: A commit made while the output is running takes effect at the next period boundary, and the period in progress completes at its old length.
- R7: Bit 0 at address 0 is the enable. Clearing it drives the output low from the next cycle and clears both counters. Setting it starts a new period whose high phase begins in the first cycle.
- R8: When the 2-bit mode field at address 4 bits [1:0] equals 3, staged values are copied into the live set at each period boundary without a commit. With any other mode value, a commit is still required. The mode field reads back as written.
- R9: A live high width of 0 holds the output low. A live high width of P+1 or more holds the output high while enabled.
- R10: A commit made while the output is disabled is applied at once, so the first period after enabling already uses the new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write enable |
| addr_i | input | AW (3) | Register word address |
| wdata_i | input | DW (32) | Register write data |
| rdata_o | output | DW (32) | Register read data for `addr_i` (combinational) |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the block with its default widths: a 10-bit divider, 12-bit period, 13-bit high width, 3-bit address and 32-bit data. Writing all ones reaches the full width of every field on read-back. The bench programs small divider and period values, so each period lasts only 6 to 20 cycles. This lets it measure exact high and period lengths and place a commit inside a known period to check that the boundary is respected. It also drives the high width to zero and beyond the period to check both saturated outputs.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int ADDR_EN     = 0;
  localparam int ADDR_COMMIT = 1;
  localparam int ADDR_CTRL0  = 2;
  localparam int ADDR_CTRL1  = 3;
  localparam int ADDR_MODE   = 4;

  localparam int DIV_LSB = 16;
  localparam int PER_LSB = 0;
  localparam int HI_LSB  = 16;

  localparam logic [1:0] MODE_BYPASS = 2'b11;
endpackage

// File: rtl/bl_pwm_presc.sv
module bl_pwm_presc #(
  parameter int DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q;

  assign tick_o = en_i && (pre_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (!en_i)   pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/bl_pwm_period.sv
module bl_pwm_period #(
  parameter int PER_W = 12,
  parameter int HI_W  = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [HI_W-1:0]  hi_i,
  output logic             boundary_o,
  output logic             pwm_o
);
  logic [PER_W-1:0] cnt_q;

  assign boundary_o = tick_i && (cnt_q == per_i);
  assign pwm_o      = en_i && (HI_W'(cnt_q) < hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (boundary_o)  cnt_q <= '0;
    else if (tick_i)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int AW    = 3,
  parameter int DW    = 32,
  parameter int DIV_W = 10,
  parameter int PER_W = 12,
  parameter int HI_W  = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             boundary_i,
  output logic             en_o,
  output logic             pend_o,
  output logic [DIV_W-1:0] div_o,
  output logic [PER_W-1:0] per_o,
  output logic [HI_W-1:0]  hi_o
);
  logic             en_q, commit_q, pend_q;
  logic [1:0]       mode_q;
  logic [DIV_W-1:0] div_sh, div_wk;
  logic [PER_W-1:0] per_sh, per_wk;
  logic [HI_W-1:0]  hi_sh, hi_wk;

  logic sel_en, sel_commit, sel_ctrl0, sel_ctrl1, sel_mode;
  logic bypass, commit_set, load;

  assign sel_en     = addr_i == AW'(ADDR_EN);
  assign sel_commit = addr_i == AW'(ADDR_COMMIT);
  assign sel_ctrl0  = addr_i == AW'(ADDR_CTRL0);
  assign sel_ctrl1  = addr_i == AW'(ADDR_CTRL1);
  assign sel_mode   = addr_i == AW'(ADDR_MODE);

  assign bypass     = mode_q == MODE_BYPASS;
  assign commit_set = we_i && sel_commit && wdata_i[0] && !commit_q;
  // live set changes only between periods, or at once when stopped
  assign load       = (pend_q || bypass) && (boundary_i || !en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      commit_q <= 1'b0;
      mode_q   <= '0;
      div_sh   <= '0;
      per_sh   <= '0;
      hi_sh    <= '0;
    end else if (we_i) begin
      if (sel_en)     en_q     <= wdata_i[0];
      if (sel_commit) commit_q <= wdata_i[0];
      if (sel_mode)   mode_q   <= wdata_i[1:0];
      if (sel_ctrl0)  div_sh   <= wdata_i[DIV_LSB +: DIV_W];
      if (sel_ctrl1) begin
        per_sh <= wdata_i[PER_LSB +: PER_W];
        hi_sh  <= wdata_i[HI_LSB +: HI_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      div_wk <= '0;
      per_wk <= '0;
      hi_wk  <= '0;
    end else begin
      if (commit_set) pend_q <= 1'b1;
      else if (load)  pend_q <= 1'b0;
      if (load) begin
        div_wk <= div_sh;
        per_wk <= per_sh;
        hi_wk  <= hi_sh;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_en)     rdata_o[0] = en_q;
    if (sel_commit) rdata_o[0] = commit_q;
    if (sel_mode)   rdata_o[1:0] = mode_q;
    if (sel_ctrl0)  rdata_o[DIV_LSB +: DIV_W] = div_sh;
    if (sel_ctrl1) begin
      rdata_o[PER_LSB +: PER_W] = per_sh;
      rdata_o[HI_LSB +: HI_W]   = hi_sh;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign div_o  = div_wk;
  assign per_o  = per_wk;
  assign hi_o   = hi_wk;
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top #(
  parameter int AW    = 3,
  parameter int DW    = 32,
  parameter int DIV_W = 10,
  parameter int PER_W = 12,
  parameter int HI_W  = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          pwm_o
);
  logic             en_w, pend_w, tick_w, boundary_w;
  logic [DIV_W-1:0] div_wk;
  logic [PER_W-1:0] per_wk;
  logic [HI_W-1:0]  hi_wk;

  bl_pwm_regs #(
    .AW(AW), .DW(DW), .DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)
  ) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .boundary_i (boundary_w),
    .en_o       (en_w),
    .pend_o     (pend_w),
    .div_o      (div_wk),
    .per_o      (per_wk),
    .hi_o       (hi_wk)
  );

  bl_pwm_presc #(.DIV_W(DIV_W)) presc_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_w),
    .div_i  (div_wk),
    .tick_o (tick_w)
  );

  bl_pwm_period #(.PER_W(PER_W), .HI_W(HI_W)) period_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_w),
    .tick_i     (tick_w),
    .per_i      (per_wk),
    .hi_i       (hi_wk),
    .boundary_o (boundary_w),
    .pwm_o      (pwm_o)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int DIV_W = 10,
  parameter int PER_W = 12,
  parameter int HI_W  = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic             en_i,
  input logic             pend_i,
  input logic             boundary_i,
  input logic [DIV_W-1:0] div_i,
  input logic [PER_W-1:0] per_i,
  input logic [HI_W-1:0]  hi_i,
  input logic             pwm_i
);
  assert_off_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !pwm_i);

  assert_live_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !boundary_i) |=> ($stable(div_i) && $stable(per_i) && $stable(hi_i)));

  assert_zero_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_i == '0) |-> !pwm_i);

  assert_full_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (hi_i > HI_W'(per_i))) |-> pwm_i);

  assert_start_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i |=> (!en_i || (hi_i == '0) || pwm_i));

  assert_pend_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && boundary_i && !we_i) |=> !pend_i);
endmodule

bind bl_pwm_top bl_pwm_chk #(
  .DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .en_i       (en_w),
  .pend_i     (pend_w),
  .boundary_i (boundary_w),
  .div_i      (div_wk),
  .per_i      (per_wk),
  .hi_i       (hi_wk),
  .pwm_i      (pwm_o)
);

// File: tb/bl_pwm_top_tb_top.sv
`timescale 1ns/1ps
module bl_pwm_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        pwm_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  bl_pwm_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pwm_o(pwm_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 3'(a); wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = 3'(a);
    #1 d = rdata_o;
  endtask

  task automatic program_set(input int dv, input int pr, input int hw);
    wr(2, 32'(dv) << 16);
    wr(3, (32'(hw) << 16) | 32'(pr));
  endtask

  task automatic commit();
    wr(1, 32'd1);
    wr(1, 32'd0);
  endtask

  task automatic wait_rise(output int t);
    logic prev;
    int n;
    @(negedge clk_i);
    prev = pwm_o;
    n = 0;
    forever begin
      @(negedge clk_i);
      n++;
      if (!prev && pwm_o) break;
      prev = pwm_o;
      if (n > 5000) break;
    end
    t = cyc;
  endtask

  task automatic measure(output int hi, output int per);
    int t;
    int lo;
    wait_rise(t);
    hi = 1;
    forever begin
      @(negedge clk_i);
      if (pwm_o) hi++; else break;
    end
    lo = 1;
    forever begin
      @(negedge clk_i);
      if (!pwm_o) lo++; else break;
      if (lo > 5000) break;
    end
    per = hi + lo;
  endtask

  task automatic expect_wave(input string req, input int hi_e, input int per_e);
    int h, p;
    measure(h, p);
    chk(h == hi_e, {req, " high"}, h, hi_e);
    chk(p == per_e, {req, " period"}, p, per_e);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      chk(d == 0, "R1 reset read", d, 0);
    end
    chk(pwm_o == 1'b0, "R1 reset pwm", pwm_o, 0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(2, 32'hFFFF_FFFF);
    rd(2, d);
    chk(d == 32'h03FF_0000, "R4 ctrl0 field", d, 32'h03FF_0000);
    wr(3, 32'hFFFF_FFFF);
    rd(3, d);
    chk(d == 32'h1FFF_0FFF, "R4 ctrl1 fields", d, 32'h1FFF_0FFF);
    chk(pwm_o == 1'b0, "R5 no effect before commit", pwm_o, 0);
  endtask

  task automatic t_first_enable();
    logic [31:0] d;
    program_set(0, 9, 3);
    commit();
    wr(0, 32'd1);
    chk(pwm_o == 1'b1, "R10 high at first cycle after enable", pwm_o, 1);
    rd(0, d);
    chk(d == 32'd1, "R7 enable readback", d, 1);
    expect_wave("R2 R3 R10 div0", 3, 10);
    program_set(2, 4, 2);
    commit();
    expect_wave("R2 R3 div2", 6, 15);
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    program_set(0, 9, 3);
    commit();
    expect_wave("R5 setup", 3, 10);
    wr(3, 32'h0001_0005);
    expect_wave("R5 staged only", 3, 10);
    rd(3, d);
    chk(d == 32'h0001_0005, "R4 read returns staged", d, 32'h0001_0005);
    wr(1, 32'd1);
    rd(1, d);
    chk(d == 32'd1, "R5 commit readback", d, 1);
    wr(1, 32'd0);
    expect_wave("R5 after commit", 1, 6);
  endtask

  task automatic t_boundary();
    int t0, t1;
    program_set(0, 9, 3);
    commit();
    expect_wave("R6 setup", 3, 10);
    wait_rise(t0);
    wr(3, (32'd7 << 16) | 32'd19);
    commit();
    wait_rise(t1);
    chk((t1 - t0) == 10, "R6 old period completes", t1 - t0, 10);
    expect_wave("R6 new values", 7, 20);
  endtask

  task automatic t_bypass();
    logic [31:0] d;
    wr(4, 32'd1);
    wr(3, (32'd2 << 16) | 32'd7);
    expect_wave("R8 mode1 still staged", 7, 20);
    wr(4, 32'd3);
    rd(4, d);
    chk(d == 32'd3, "R8 mode readback", d, 3);
    expect_wave("R8 bypass live", 2, 8);
    wr(4, 32'd0);
  endtask

  task automatic t_extremes();
    int bad;
    program_set(0, 7, 0);
    commit();
    repeat (30) @(negedge clk_i);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (pwm_o) bad++;
    end
    chk(bad == 0, "R9 zero width low", bad, 0);
    program_set(0, 7, 8);
    commit();
    repeat (30) @(negedge clk_i);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (!pwm_o) bad++;
    end
    chk(bad == 0, "R9 width p+1 high", bad, 0);
  endtask

  task automatic t_disable();
    int bad, h;
    program_set(0, 9, 3);
    commit();
    expect_wave("R7 setup", 3, 10);
    repeat (1) @(negedge clk_i);
    wr(0, 32'd0);
    chk(pwm_o == 1'b0, "R7 low after disable", pwm_o, 0);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (pwm_o) bad++;
    end
    chk(bad == 0, "R7 stays low", bad, 0);
    wr(0, 32'd1);
    chk(pwm_o == 1'b1, "R7 restart high", pwm_o, 1);
    h = 1;
    forever begin
      @(negedge clk_i);
      if (pwm_o) h++; else break;
      if (h > 100) break;
    end
    chk(h == 3, "R7 counters cleared", h, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_fields();
    t_first_enable();
    t_shadow();
    t_boundary();
    t_bypass();
    t_extremes();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule